// File: doc/BRIEF.md
# Quadrature Position Counter with Index and Strobe Capture

This block turns the two phase lines of an incremental encoder, already cleaned of glitches and brought into the local clock domain, into a position count. The two lines form a 2-bit Gray code. Each legal one-step change of that code adds or removes one count, and a configuration bit picks which rotation counts upward. The count runs over a range from 0 to a programmable wrap value and rolls over at both ends. For each accepted step the block gives a one-cycle step pulse and a direction flag, which downstream speed measurement logic uses.

Two capture registers hold copies of the count. The index register takes the count on the chosen edge of the encoder's index line. The strobe register takes the count on the rising edge of an external sync strobe, for example one from the PWM, when sync capture is switched on. A change of both lines in the same sample is not counted. It sets a sticky error flag instead.

After a system reset the block stays idle. It starts only after a module reset pulse has been given and while the enable input is high.

Top module: `quad_pos_counter`

## Requirements
- R1: After `rst`, every output is 0. Until the first `soft_rst` pulse after `rst`, no count, capture, error or step pulse happens, even with `enable` high and the lines moving.
- R2: The phase code is {`line_a`,`line_b`}. The forward sequence is 00, 01, 11, 10, 00. With `cfg_dir_neg`=0, each forward step adds 1 to `pos_count` and each reverse step subtracts 1. The inputs are sampled on one rising edge and `pos_count` changes on the next rising edge. With no step, `pos_count` holds.
- R3: With `cfg_dir_neg`=1, forward steps subtract 1 and reverse steps add 1.
- R4: An up count from a value equal to or above `wrap_val` gives 0. A down count from 0 gives `wrap_val`.
- R5: A sample in which both lines changed gives no count and sets `err_sticky`. The flag stays at 1 until `soft_rst` or `rst`.
- R6: With `cfg_idx_mode`=01, a rising edge of `line_idx` loads `idx_latch` with `pos_count` as it stood before that edge's update. With `cfg_idx_mode`=10, a falling edge does the same. Codes 00 and 11 never load it.
- R7: With `cfg_sync_en`=1, a rising edge of the OR of the three `sync_strobe` bits loads `strobe_latch` with `pos_count` in the same way. With `cfg_sync_en`=0, strobes are ignored.
- R8: `step_pulse` is high for exactly one cycle, in the same cycle in which `pos_count` takes each counted step. `step_dir` is 1 when that step was upward and 0 when it was downward, and it holds between steps.
- R9: While `enable` is 0, no count, capture, error or step pulse happens. Line samples are still tracked, so raising `enable` again causes no spurious count.
- R10: `soft_rst` clears `pos_count`, both latches, `err_sticky`, `step_pulse` and `step_dir`, and arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| soft_rst | input | 1 | Module reset pulse; clears state and arms the block |
| enable | input | 1 | Count enable |
| line_a | input | 1 | Encoder phase A, conditioned |
| line_b | input | 1 | Encoder phase B, conditioned |
| line_idx | input | 1 | Encoder index line, conditioned |
| sync_strobe | input | 3 | External sync strobe bits; any high bit is a strobe |
| cfg_dir_neg | input | 1 | 0: forward counts up; 1: forward counts down |
| cfg_idx_mode | input | 2 | Index capture edge: 01 rising, 10 falling, others off |
| cfg_sync_en | input | 1 | Enables strobe capture |
| wrap_val | input | 32 | Top of the count range |
| pos_count | output | 32 | Position count |
| idx_latch | output | 32 | Count captured at the index edge |
| strobe_latch | output | 32 | Count captured at the sync strobe |
| step_pulse | output | 1 | One-cycle pulse per counted step |
| step_dir | output | 1 | Direction of the last counted step, 1 = up |
| err_sticky | output | 1 | Sticky flag for a step in which both lines changed |

## Verification
Each line, index and strobe input is registered at the first rising edge after it changes. The count, the captures, the step pulse and the error flag take the new value at the second rising edge, while `soft_rst` and `enable` act at the first edge at which they are seen. The bench drives inputs at the falling edge. It advances a reference model at every rising edge with exactly that two-stage delay. It compares all outputs at the following falling edge. Directed checks sample one falling edge after the move for the still-old value, then one cycle later for the new one.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        IDX_OFF  = 2'b00,
        IDX_RISE = 2'b01,
        IDX_FALL = 2'b10,
        IDX_RSVD = 2'b11
    } idx_mode_e;

    typedef struct packed {
        logic step;
        logic up;
        logic illegal;
    } step_evt_t;

    // Position of a phase code within the forward cycle 00,01,11,10
    function automatic logic [1:0] gray_phase(input logic [1:0] ab);
        case (ab)
            2'b00:   gray_phase = 2'd0;
            2'b01:   gray_phase = 2'd1;
            2'b11:   gray_phase = 2'd2;
            default: gray_phase = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/qpc_edge.sv
module qpc_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] sig,
    input  logic         rise_en,
    input  logic         fall_en,
    output logic         hit
);
    logic cur_q;
    logic prev_q;

    // Sample stage runs even in reset so it is settled when reset ends
    always_ff @(posedge clk) begin
        cur_q  <= |sig;
        prev_q <= cur_q;
    end

    always_comb begin
        hit = (rise_en && cur_q && !prev_q) || (fall_en && !cur_q && prev_q);
    end
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic      clk,
    input  logic      line_a,
    input  logic      line_b,
    input  logic      active,
    input  logic      dir_neg,
    output step_evt_t evt
);
    logic [1:0] cur_ab;
    logic [1:0] prev_ab;
    logic [1:0] delta;

    always_ff @(posedge clk) begin
        cur_ab  <= {line_a, line_b};
        prev_ab <= cur_ab;
    end

    always_comb begin
        delta       = gray_phase(cur_ab) - gray_phase(prev_ab);
        evt.step    = active && (delta == 2'd1 || delta == 2'd3);
        evt.up      = (delta == 2'd1) ^ dir_neg;
        evt.illegal = active && (delta == 2'd2);
    end
endmodule

// File: rtl/qpc_position.sv
module qpc_position
    import qpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  step_evt_t        evt,
    input  logic [CNT_W-1:0] wrap,
    output logic [CNT_W-1:0] count,
    output logic             step_pulse,
    output logic             step_dir
);
    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        if (evt.up) begin
            count_nxt = (count >= wrap) ? '0 : count + 1'b1;
        end else begin
            count_nxt = (count == '0) ? wrap : count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count      <= '0;
            step_pulse <= 1'b0;
            step_dir   <= 1'b0;
        end else begin
            step_pulse <= evt.step;
            if (evt.step) begin
                count    <= count_nxt;
                step_dir <= evt.up;
            end
        end
    end
endmodule

// File: rtl/qpc_capture.sv
module qpc_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fire,
    input  logic [CNT_W-1:0] src,
    output logic [CNT_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held <= '0;
        end else if (fire) begin
            held <= src;
        end
    end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STRB_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              enable,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              line_idx,
    input  logic [STRB_W-1:0] sync_strobe,
    input  logic              cfg_dir_neg,
    input  logic [1:0]        cfg_idx_mode,
    input  logic              cfg_sync_en,
    input  logic [CNT_W-1:0]  wrap_val,
    output logic [CNT_W-1:0]  pos_count,
    output logic [CNT_W-1:0]  idx_latch,
    output logic [CNT_W-1:0]  strobe_latch,
    output logic              step_pulse,
    output logic              step_dir,
    output logic              err_sticky
);
    logic      armed;
    logic      active;
    logic      idx_hit;
    logic      strb_hit;
    step_evt_t evt;
    idx_mode_e idx_mode;

    always_comb begin
        idx_mode = idx_mode_e'(cfg_idx_mode);
        active   = armed && enable && !soft_rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            err_sticky <= 1'b0;
        end else if (soft_rst) begin
            armed      <= 1'b1;
            err_sticky <= 1'b0;
        end else if (evt.illegal) begin
            err_sticky <= 1'b1;
        end
    end

    qpc_decoder u_dec (
        .clk     (clk),
        .line_a  (line_a),
        .line_b  (line_b),
        .active  (active),
        .dir_neg (cfg_dir_neg),
        .evt     (evt)
    );

    qpc_position #(.CNT_W(CNT_W)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .clr        (soft_rst),
        .evt        (evt),
        .wrap       (wrap_val),
        .count      (pos_count),
        .step_pulse (step_pulse),
        .step_dir   (step_dir)
    );

    qpc_edge #(.W(1)) u_idx_edge (
        .clk     (clk),
        .sig     (line_idx),
        .rise_en (active && idx_mode == IDX_RISE),
        .fall_en (active && idx_mode == IDX_FALL),
        .hit     (idx_hit)
    );

    qpc_edge #(.W(STRB_W)) u_strb_edge (
        .clk     (clk),
        .sig     (sync_strobe),
        .rise_en (active && cfg_sync_en),
        .fall_en (1'b0),
        .hit     (strb_hit)
    );

    qpc_capture #(.CNT_W(CNT_W)) u_idx_cap (
        .clk  (clk),
        .rst  (rst),
        .clr  (soft_rst),
        .fire (idx_hit),
        .src  (pos_count),
        .held (idx_latch)
    );

    qpc_capture #(.CNT_W(CNT_W)) u_strb_cap (
        .clk  (clk),
        .rst  (rst),
        .clr  (soft_rst),
        .fire (strb_hit),
        .src  (pos_count),
        .held (strobe_latch)
    );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             enable,
    input logic [CNT_W-1:0] wrap_val,
    input logic [CNT_W-1:0] pos_count,
    input logic             step_pulse,
    input logic             step_dir,
    input logic             err_sticky
);
    p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
        step_pulse && step_dir && ($past(pos_count) < $past(wrap_val))
        |-> pos_count == $past(pos_count) + 1'b1);

    p_dn_step_r2: assert property (@(posedge clk) disable iff (rst)
        step_pulse && !step_dir && ($past(pos_count) != '0)
        |-> pos_count == $past(pos_count) - 1'b1);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step_pulse && !$past(soft_rst) && !$past(rst) |-> $stable(pos_count));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
        step_pulse && step_dir && ($past(pos_count) >= $past(wrap_val))
        |-> pos_count == '0);

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
        step_pulse && !step_dir && ($past(pos_count) == '0)
        |-> pos_count == $past(wrap_val));

    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        err_sticky && !soft_rst |=> err_sticky);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !step_pulse);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) && !$past(rst) |-> pos_count == '0 && !err_sticky && !step_pulse);
endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0;
    logic enable = 1'b0;
    logic line_a = 1'b0;
    logic line_b = 1'b0;
    logic line_idx = 1'b0;
    logic [2:0] sync_strobe = 3'b000;
    logic cfg_dir_neg = 1'b0;
    logic [1:0] cfg_idx_mode = 2'b00;
    logic cfg_sync_en = 1'b0;
    logic [W-1:0] wrap_val = '0;
    logic [W-1:0] pos_count, idx_latch, strobe_latch;
    logic step_pulse, step_dir, err_sticky;

    quad_pos_counter u_quad_pos_counter (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .enable(enable),
        .line_a(line_a), .line_b(line_b), .line_idx(line_idx),
        .sync_strobe(sync_strobe), .cfg_dir_neg(cfg_dir_neg),
        .cfg_idx_mode(cfg_idx_mode), .cfg_sync_en(cfg_sync_en),
        .wrap_val(wrap_val), .pos_count(pos_count), .idx_latch(idx_latch),
        .strobe_latch(strobe_latch), .step_pulse(step_pulse),
        .step_dir(step_dir), .err_sticky(err_sticky)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    string tag = "R1";
    int g = 0;

    logic [W-1:0] m_cnt = '0, m_il = '0, m_sl = '0;
    logic m_err = 0, m_step = 0, m_dir = 0, m_armed = 0;
    logic [1:0] m_cur = 2'b00, m_prev = 2'b00;
    logic m_icur = 0, m_iprev = 0, m_scur = 0, m_sprev = 0;

    task automatic chk(string t, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    function automatic int gph(logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] g2ab(int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic model_edge();
        int d;
        logic act, up, ifire, sfire;
        if (rst) begin
            m_cnt = '0; m_il = '0; m_sl = '0; m_err = 0;
            m_step = 0; m_dir = 0; m_armed = 0;
        end else if (soft_rst) begin
            m_cnt = '0; m_il = '0; m_sl = '0; m_err = 0;
            m_step = 0; m_dir = 0; m_armed = 1;
        end else begin
            act = m_armed && enable;
            d = (gph(m_cur) - gph(m_prev)) & 3;
            ifire = act && ((cfg_idx_mode == 2'b01 && m_icur && !m_iprev) ||
                            (cfg_idx_mode == 2'b10 && !m_icur && m_iprev));
            sfire = act && cfg_sync_en && m_scur && !m_sprev;
            if (ifire) m_il = m_cnt;
            if (sfire) m_sl = m_cnt;
            if (act && d == 2) m_err = 1;
            if (act && (d == 1 || d == 3)) begin
                up = (d == 1) ^ cfg_dir_neg;
                if (up) m_cnt = (m_cnt >= wrap_val) ? '0 : m_cnt + 1;
                else    m_cnt = (m_cnt == '0) ? wrap_val : m_cnt - 1;
                m_step = 1;
                m_dir = up;
            end else begin
                m_step = 0;
            end
        end
        m_prev = m_cur;   m_cur = {line_a, line_b};
        m_iprev = m_icur; m_icur = line_idx;
        m_sprev = m_scur; m_scur = |sync_strobe;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "pos_count", pos_count, m_cnt);
        chk("R6", "idx_latch", idx_latch, m_il);
        chk("R7", "strobe_latch", strobe_latch, m_sl);
        chk("R5", "err_sticky", {31'b0, err_sticky}, {31'b0, m_err});
        chk("R8", "step_pulse", {31'b0, step_pulse}, {31'b0, m_step});
        chk("R8", "step_dir", {31'b0, step_dir}, {31'b0, m_dir});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic move(int dn);
        g = (g + dn) & 3;
        {line_a, line_b} = g2ab(g);
        tick();
    endtask

    task automatic pulse_soft();
        soft_rst = 1; tick(); soft_rst = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        rst = 1; idle(4);
        chk("R1", "reset pos", pos_count, 0);
        chk("R1", "reset step", {31'b0, step_pulse}, 0);
        rst = 0;
        enable = 1; wrap_val = 1000;
        for (int i = 0; i < 4; i++) move(1);
        idle(2);
        chk("R1", "unarmed pos", pos_count, 0);

        tag = "R10"; pulse_soft(); idle(1);
        chk("R10", "after soft", pos_count, 0);

        tag = "R2";
        for (int i = 0; i < 6; i++) move(1);
        idle(2); chk("R2", "fwd six", pos_count, 6);
        for (int i = 0; i < 3; i++) move(-1);
        idle(2); chk("R2", "rev three", pos_count, 3);

        tag = "R3"; cfg_dir_neg = 1;
        for (int i = 0; i < 5; i++) move(1);
        idle(2); chk("R3", "neg dir", pos_count, 999);

        tag = "R4"; cfg_dir_neg = 0; pulse_soft(); wrap_val = 5;
        for (int i = 0; i < 8; i++) move(1);
        idle(2); chk("R4", "wrap up", pos_count, 2);
        for (int i = 0; i < 3; i++) move(-1);
        idle(2); chk("R4", "wrap down", pos_count, 5);

        tag = "R5"; move(2); idle(2);
        chk("R5", "illegal err", {31'b0, err_sticky}, 1);
        chk("R5", "illegal no count", pos_count, 5);
        move(1); idle(3);
        chk("R5", "err sticky", {31'b0, err_sticky}, 1);

        tag = "R8"; move(1);
        chk("R8", "step not yet", {31'b0, step_pulse}, 0);
        tick();
        chk("R8", "step now", {31'b0, step_pulse}, 1);
        chk("R8", "dir up", {31'b0, step_dir}, 1);
        tick();
        chk("R8", "step one cycle", {31'b0, step_pulse}, 0);

        tag = "R6"; wrap_val = 1000; pulse_soft();
        for (int i = 0; i < 3; i++) move(1);
        idle(2);
        cfg_idx_mode = 2'b01; line_idx = 1; idle(3);
        chk("R6", "rise capture", idx_latch, 3);
        move(1); line_idx = 0; idle(3);
        chk("R6", "fall ignored in rise mode", idx_latch, 3);
        cfg_idx_mode = 2'b10; move(1); line_idx = 1; idle(3);
        chk("R6", "rise ignored in fall mode", idx_latch, 3);
        line_idx = 0; idle(3);
        chk("R6", "fall capture", idx_latch, 5);
        cfg_idx_mode = 2'b11; move(1); line_idx = 1; idle(2); line_idx = 0; idle(3);
        chk("R6", "mode 11 off", idx_latch, 5);

        tag = "R7"; cfg_sync_en = 0; sync_strobe = 3'b100; idle(3);
        chk("R7", "strobe disabled", strobe_latch, 0);
        sync_strobe = 0; cfg_sync_en = 1; idle(2);
        sync_strobe = 3'b010; idle(3);
        chk("R7", "strobe capture", strobe_latch, 6);
        sync_strobe = 0;

        tag = "R9"; pulse_soft(); idle(1); enable = 0;
        move(1); move(1); move(2);
        line_idx = 1; cfg_idx_mode = 2'b01; sync_strobe = 3'b001; idle(3);
        chk("R9", "disabled pos", pos_count, 0);
        chk("R9", "disabled err", {31'b0, err_sticky}, 0);
        chk("R9", "disabled idx", idx_latch, 0);
        enable = 1; idle(3);
        chk("R9", "reenable no count", pos_count, 0);
        line_idx = 0; sync_strobe = 0; idle(2);

        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 55)      g = (g + ($urandom_range(0, 1) ? 1 : -1)) & 3;
            else if (r < 58) g = (g + 2) & 3;
            {line_a, line_b} = g2ab(g);
            if ($urandom_range(0, 9) == 0) line_idx = ~line_idx;
            if ($urandom_range(0, 9) == 0) sync_strobe = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 49) == 0) cfg_idx_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) cfg_dir_neg = ~cfg_dir_neg;
            if ($urandom_range(0, 99) == 0) cfg_sync_en = ~cfg_sync_en;
            if ($urandom_range(0, 199) == 0) wrap_val = W'($urandom_range(0, 12));
            enable = ($urandom_range(0, 29) != 0);
            soft_rst = ($urandom_range(0, 149) == 0);
            tick();
        end
        soft_rst = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule